// File: doc/BRIEF.md
# Exclusive Two-Level Placement Sequencer

This block sits beside a private cache hierarchy. The hierarchy has two first-level arrays, one for instruction fetches and one for data accesses, and a second-level array that is exclusive of both. For each processor request the block picks one placement event and the address that event applies to. It also carries out any line copy the event needs, using a small transfer sequencer over a one-line buffer.

The block looks at the request kind and address, at the tag-present and room flags of all three arrays, and at the victim addresses the arrays offer. From these it decides whether the request can go ahead as a demand access. If it cannot, the block first stages a line between levels or frees a second-level victim. Exclusion means a line lives in at most one array. A line found in the wrong first-level array therefore goes down to the second level first, and so does a first-level victim that has to make room. If the second level has no room for that line, the block first replaces a second-level victim.

A move or replacement does not consume the request. Once the transfer completes, the request is evaluated again, and it is taken only when it yields a demand event. A request that arrives while its line is in a transient coherence state is sent back for a later retry.

Top module: `xl_place_seq`

## Requirements
- R1: A fetch whose line is present in the data array, or a data access whose line is present in the instruction array, gives a move-down event (code 1) at the request address, sourced from that wrong array, when the second level has room for the request address.
- R2: In the R1 case without second-level room, the event is a second-level replacement (code 4) at the second-level victim address offered for the request address.
- R3: A request whose line is present in its own first-level array gives a demand event (code 0) at the request address, and the request is taken.
- R4: When the own first-level array misses but has room, a second-level hit gives a move-up event at the request address: code 2 into the instruction array for a fetch, code 3 into the data array for a data access. A second-level miss gives a demand event.
- R5: When the own first-level array misses with no room, the own first-level victim address is used. The event is a move-down from the own array at that address if the second level has room for it. Otherwise it is a replacement at the second-level victim offered for that victim address.
- R6: Array codes are 0 for instruction, 1 for data and 2 for second level. A move-down writes the second level and frees the source first-level array. A move-up writes the own first-level array and frees the second level. A replacement frees the second level and writes nothing. The written data is the source line captured when the decision is made.
- R7: The instruction, data and second-level present flags are never asserted together in any pair while a request is valid. An assertion flags any violation.
- R8: A request marked not stable produces a recycle pulse and no event.
- R9: An event appears in the cycle after the decision edge. For moves and replacements, the transfer strobes are active in that same cycle and the done pulse comes one cycle later. No new decision is made until the block is idle again.
- R10: A move or replacement does not take the request. A request held valid is re-evaluated after done, and it is taken once it yields a demand event.
- R11: After reset, no event, take, recycle, transfer strobe or done is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request pending |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_stable | input | 1 | Line is in a stable coherence state |
| req_addr | input | AW | Request line address |
| hit_i | input | 1 | Request tag present in instruction array |
| hit_d | input | 1 | Request tag present in data array |
| hit_l2 | input | 1 | Request tag present in second level |
| room_i | input | 1 | Instruction array has a free way for request |
| room_d | input | 1 | Data array has a free way for request |
| room_l2_req | input | 1 | Second level has room for the request address |
| room_l2_vic | input | 1 | Second level has room for the first-level victim address |
| vic_i_addr | input | AW | Instruction-array victim for the request |
| vic_d_addr | input | AW | Data-array victim for the request |
| vic_l2_req_addr | input | AW | Second-level victim for the request address |
| vic_l2_vic_addr | input | AW | Second-level victim for the first-level victim address |
| line_i | input | LW | Instruction-array line read at the chosen address |
| line_d | input | LW | Data-array line read at the chosen address |
| line_l2 | input | LW | Second-level line read at the chosen address |
| ev_valid | output | 1 | Event pulse |
| ev_code | output | 3 | 0 demand, 1 move-down, 2 move-up to instruction, 3 move-up to data, 4 second-level replacement |
| ev_addr | output | AW | Address the event applies to |
| req_take | output | 1 | Request consumed |
| req_recycle | output | 1 | Request sent back for retry |
| xf_we | output | 1 | Write line into destination array |
| xf_free | output | 1 | Free the source entry |
| xf_src | output | 2 | Source array code |
| xf_dst | output | 2 | Destination array code |
| xf_addr | output | AW | Transfer address |
| xf_data | output | LW | Transfer line data |
| xf_done | output | 1 | Transfer finished pulse |

## Verification
The checker watches the exclusion invariant on every valid cycle. It also checks, on every cycle, that a write always comes with a free of a different array, that a free is always followed by a done pulse, that no event shows up during recycle or done, and that a take occurs only with a demand event. Only the bench scenarios can show that each combination of presence, room and victim flags yields the right event code, address, source and line data. The same holds for re-evaluating a held request through a chain of move-down, move-up and demand.

// File: rtl/xl_place_seq.sv
module xl_place_seq #(
  parameter int AW = 12,
  parameter int LW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_fetch,
  input  logic          req_stable,
  input  logic [AW-1:0] req_addr,
  input  logic          hit_i,
  input  logic          hit_d,
  input  logic          hit_l2,
  input  logic          room_i,
  input  logic          room_d,
  input  logic          room_l2_req,
  input  logic          room_l2_vic,
  input  logic [AW-1:0] vic_i_addr,
  input  logic [AW-1:0] vic_d_addr,
  input  logic [AW-1:0] vic_l2_req_addr,
  input  logic [AW-1:0] vic_l2_vic_addr,
  input  logic [LW-1:0] line_i,
  input  logic [LW-1:0] line_d,
  input  logic [LW-1:0] line_l2,
  output logic          ev_valid,
  output logic [2:0]    ev_code,
  output logic [AW-1:0] ev_addr,
  output logic          req_take,
  output logic          req_recycle,
  output logic          xf_we,
  output logic          xf_free,
  output logic [1:0]    xf_src,
  output logic [1:0]    xf_dst,
  output logic [AW-1:0] xf_addr,
  output logic [LW-1:0] xf_data,
  output logic          xf_done
);
  localparam logic [2:0] EV_DEMAND = 3'd0, EV_DOWN = 3'd1, EV_UP_I = 3'd2,
                         EV_UP_D = 3'd3, EV_REPL = 3'd4;
  localparam logic [1:0] A_I = 2'd0, A_D = 2'd1, A_L2 = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_DONE} st_t;
  st_t st;

  logic [2:0]    code_q;
  logic [AW-1:0] addr_q;
  logic          evv_q, take_q, recyc_q, we_q;
  logic [1:0]    src_q, dst_q;
  logic [LW-1:0] buf_q;

  wire own_hit   = req_fetch ? hit_i  : hit_d;
  wire wrong_hit = req_fetch ? hit_d  : hit_i;
  wire own_room  = req_fetch ? room_i : room_d;
  wire [AW-1:0] own_vic = req_fetch ? vic_i_addr : vic_d_addr;
  wire [1:0] own_arr   = req_fetch ? A_I : A_D;
  wire [1:0] wrong_arr = req_fetch ? A_D : A_I;

  logic [2:0]    n_code;
  logic [AW-1:0] n_addr;
  logic [1:0]    n_src, n_dst;

  always_comb begin
    n_src = A_L2;
    n_dst = A_L2;
    if (wrong_hit) begin
      if (room_l2_req) begin
        n_code = EV_DOWN; n_addr = req_addr; n_src = wrong_arr;
      end else begin
        n_code = EV_REPL; n_addr = vic_l2_req_addr;
      end
    end else if (own_hit) begin
      n_code = EV_DEMAND; n_addr = req_addr;
    end else if (own_room) begin
      n_addr = req_addr;
      if (hit_l2) begin
        n_code = req_fetch ? EV_UP_I : EV_UP_D; n_dst = own_arr;
      end else begin
        n_code = EV_DEMAND;
      end
    end else begin
      if (room_l2_vic) begin
        n_code = EV_DOWN; n_addr = own_vic; n_src = own_arr;
      end else begin
        n_code = EV_REPL; n_addr = vic_l2_vic_addr;
      end
    end
  end

  wire decide = req_valid && st == S_IDLE && !evv_q && !recyc_q;
  wire go     = decide && req_stable;
  wire is_mv  = n_code == EV_DOWN || n_code == EV_UP_I || n_code == EV_UP_D;

  logic [LW-1:0] src_line;
  always_comb begin
    case (n_src)
      A_I:     src_line = line_i;
      A_D:     src_line = line_d;
      default: src_line = line_l2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      evv_q   <= 1'b0;
      take_q  <= 1'b0;
      recyc_q <= 1'b0;
      we_q    <= 1'b0;
      code_q  <= '0;
      addr_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      buf_q   <= '0;
    end else begin
      evv_q   <= go;
      take_q  <= go && n_code == EV_DEMAND;
      recyc_q <= decide && !req_stable;
      case (st)
        S_IDLE: if (go && n_code != EV_DEMAND) st <= S_XFER;
        S_XFER: st <= S_DONE;
        default: st <= S_IDLE;
      endcase
      if (go) begin
        code_q <= n_code;
        addr_q <= n_addr;
        src_q  <= n_src;
        dst_q  <= n_dst;
        we_q   <= is_mv;
        buf_q  <= src_line;
      end
    end
  end

  assign ev_valid    = evv_q;
  assign ev_code     = code_q;
  assign ev_addr     = addr_q;
  assign req_take    = take_q;
  assign req_recycle = recyc_q;
  assign xf_free     = st == S_XFER;
  assign xf_we       = xf_free && we_q;
  assign xf_src      = src_q;
  assign xf_dst      = dst_q;
  assign xf_addr     = addr_q;
  assign xf_data     = buf_q;
  assign xf_done     = st == S_DONE;
endmodule

// File: rtl/xl_place_seq_chk.sv
module xl_place_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       hit_i,
  input logic       hit_d,
  input logic       hit_l2,
  input logic       ev_valid,
  input logic [2:0] ev_code,
  input logic       req_take,
  input logic       req_recycle,
  input logic       xf_we,
  input logic       xf_free,
  input logic [1:0] xf_src,
  input logic [1:0] xf_dst,
  input logic       xf_done
);
  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({hit_i, hit_d, hit_l2}) <= 1);

  p_write_pairs_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xf_we |-> (xf_free && xf_src != xf_dst));

  p_free_then_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xf_free |=> xf_done);

  p_move_has_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_code != 3'd0) |-> xf_free);

  p_recycle_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_recycle |-> !ev_valid);

  p_take_on_demand_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |-> (ev_valid && ev_code == 3'd0));

  p_quiet_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xf_done |-> !ev_valid && !xf_free);
endmodule

bind xl_place_seq xl_place_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .hit_i(hit_i), .hit_d(hit_d), .hit_l2(hit_l2),
  .ev_valid(ev_valid), .ev_code(ev_code), .req_take(req_take),
  .req_recycle(req_recycle), .xf_we(xf_we), .xf_free(xf_free),
  .xf_src(xf_src), .xf_dst(xf_dst), .xf_done(xf_done)
);

// File: tb/xl_place_seq_tb_top.sv
module xl_place_seq_tb_top;
  localparam int AW = 12, LW = 32;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_fetch = 0, req_stable = 1;
  logic hit_i = 0, hit_d = 0, hit_l2 = 0, room_i = 0, room_d = 0;
  logic room_l2_req = 0, room_l2_vic = 0;
  logic [AW-1:0] req_addr = 12'h100, vic_i_addr = 12'h210, vic_d_addr = 12'h320;
  logic [AW-1:0] vic_l2_req_addr = 12'h430, vic_l2_vic_addr = 12'h540;
  logic [LW-1:0] line_i = 32'hAAAA0001, line_d = 32'hDDDD0002, line_l2 = 32'h2222EEEE;
  logic ev_valid, req_take, req_recycle, xf_we, xf_free, xf_done;
  logic [2:0] ev_code;
  logic [AW-1:0] ev_addr, xf_addr;
  logic [1:0] xf_src, xf_dst;
  logic [LW-1:0] xf_data;

  xl_place_seq #(.AW(AW), .LW(LW)) dut_i (.*);

  int checks = 0, errors = 0;
  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // {fetch, hit_i, hit_d, hit_l2, room_i, room_d, room_l2_req, room_l2_vic, stable, code, addr sel, src}
  // code 7 = expect recycle; addr sel 0 req,1 vic_i,2 vic_d,3 vic_l2_req,4 vic_l2_vic
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {9'b1_010_00_10_1, 3'd1, 3'd0, 2'd1},  // R1 fetch in data array
    {9'b0_100_00_10_1, 3'd1, 3'd0, 2'd0},  // R1 data in instr array
    {9'b1_010_00_00_1, 3'd4, 3'd3, 2'd2},  // R2
    {9'b1_100_00_00_1, 3'd0, 3'd0, 2'd0},  // R3 fetch own hit
    {9'b0_010_00_00_1, 3'd0, 3'd0, 2'd0},  // R3 data own hit
    {9'b1_001_10_00_1, 3'd2, 3'd0, 2'd2},  // R4 up to instr
    {9'b0_001_01_00_1, 3'd3, 3'd0, 2'd2},  // R4 up to data
    {9'b0_000_01_00_1, 3'd0, 3'd0, 2'd0},  // R4 l2 miss demand
    {9'b1_000_00_01_1, 3'd1, 3'd1, 2'd0},  // R5 victim down
    {9'b0_000_00_00_1, 3'd4, 3'd4, 2'd2},  // R5 victim replace
    {9'b0_000_00_01_1, 3'd1, 3'd2, 2'd1},  // R5 data victim down
    {9'b1_100_00_00_0, 3'd7, 3'd0, 2'd0}   // R8 transient
  };

  function automatic logic [AW-1:0] sel_addr(input logic [2:0] s);
    case (s)
      3'd1: return vic_i_addr;
      3'd2: return vic_d_addr;
      3'd3: return vic_l2_req_addr;
      3'd4: return vic_l2_vic_addr;
      default: return req_addr;
    endcase
  endfunction

  task automatic check_event(input string r, input logic [2:0] code, input logic [2:0] asel,
                             input logic [1:0] src);
    logic [1:0] dst;
    logic [LW-1:0] dat;
    if (code == 3'd7) begin
      chk({r, " recycle"}, req_recycle, 1'b1);
      chk({r, " no event"}, ev_valid, 1'b0);
      return;
    end
    chk({r, " ev_valid"}, ev_valid, 1'b1);
    chk({r, " ev_code"}, ev_code, code);
    chk({r, " ev_addr"}, ev_addr, sel_addr(asel));
    if (code == 3'd0) begin
      chk({r, " take"}, req_take, 1'b1);
      chk({r, " no xfer"}, xf_free, 1'b0);
      return;
    end
    chk({r, " R10 no take on move"}, req_take, 1'b0);
    chk({r, " R6 free"}, xf_free, 1'b1);
    chk({r, " R6 src"}, xf_src, src);
    chk({r, " R6 we"}, xf_we, code != 3'd4);
    if (code != 3'd4) begin
      dst = (code == 3'd1) ? 2'd2 : (code == 3'd2 ? 2'd0 : 2'd1);
      dat = (src == 2'd0) ? line_i : (src == 2'd1 ? line_d : line_l2);
      chk({r, " R6 dst"}, xf_dst, dst);
      chk({r, " R6 data"}, xf_data, dat);
    end
    chk({r, " R9 addr"}, xf_addr, sel_addr(asel));
    @(negedge clk);
    chk({r, " R9 done"}, xf_done, 1'b1);
    chk({r, " R9 strobes off"}, xf_free, 1'b0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 ev_valid", ev_valid, 0);
    chk("R11 take", req_take, 0);
    chk("R11 recycle", req_recycle, 0);
    chk("R11 free", xf_free, 0);
    chk("R11 done", xf_done, 0);

    for (int k = 0; k < NV; k++) begin
      {req_fetch, hit_i, hit_d, hit_l2, room_i, room_d, room_l2_req, room_l2_vic, req_stable}
        = VEC[k][16:8];
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      check_event($sformatf("vec%0d", k), VEC[k][7:5], VEC[k][4:2], VEC[k][1:0]);
      repeat (2) @(negedge clk);
    end

    // R10: held request walks move-down, move-up, then demand
    req_stable = 1; req_fetch = 1;
    {hit_i, hit_d, hit_l2, room_i, room_d, room_l2_req, room_l2_vic} = 7'b010_00_10;
    req_valid = 1;
    @(negedge clk);
    check_event("R10 step1", 3'd1, 3'd0, 2'd1);
    {hit_i, hit_d, hit_l2, room_i} = 4'b0011;
    @(negedge clk);
    chk("R9 idle gap no event", ev_valid, 0);
    @(negedge clk);
    check_event("R10 step2", 3'd2, 3'd0, 2'd2);
    {hit_i, hit_d, hit_l2} = 3'b100;
    repeat (2) @(negedge clk);
    check_event("R10 step3", 3'd0, 3'd0, 2'd0);
    req_valid = 0;
    repeat (3) @(negedge clk);
    chk("R10 no further take", req_take, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule